// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit is the shared status and control register bank that sits beside a set of DMA channel engines. Each channel raises hardware pulses for completion, termination error and bus error. The unit latches them into status registers, masks the completion flags with per-channel enables, and combines the result into one interrupt line. It also presents the single most urgent pending event as a bit index. Errors outrank completions. Within each group the higher channel wins.

Software reaches the unit through a simple register port. Every register has three addresses: a plain one, a set alias that ORs in the written bits, and a clear alias that removes them. These aliases let an interrupt handler acknowledge exactly the flags it read without a read-modify-write race. The same bank holds per-channel freeze bits, one-cycle channel reset requests, and two burst-enable bits.

An error is classified per channel. A termination error that is latched together with a completion for the same channel is reported as a completion, not as a failure.

Top module: `dma_irq_csr`

## Requirements
- R1: The completion register (offset 0x00) latches `cmpl_evt_i[c]` into bit c (bits 15:0); bits 31:16 are per-channel completion interrupt enables written only by software.
- R2: The error register (offset 0x10) latches `term_err_evt_i[c]` into bit c and `bus_err_evt_i[c]` into bit 16+c.
- R3: For each register base B, a write to B replaces the writable bits, a write to B+0x4 ORs the data in, and a write to B+0x8 clears the bits set in the data. Reads of B, B+0x4 and B+0x8 all return the register. Offset B+0xC reads zero and ignores writes.
- R4: When a hardware event and a software clear target the same status bit in the same cycle, the bit ends up set.
- R5: The channel control register (offset 0x20) drives `freeze_o` from bits 15:0. Bits 31:16 drive `chan_rst_o`; a requested reset bit is high for exactly the one cycle after the write and then reads back as zero.
- R6: The global register (offset 0x30) keeps only bits 28 and 29, which drive `burst_en_o[0]` and `burst_en_o[1]`; all its other bits read zero.
- R7: `irq_o` is high whenever any completion bit has its enable set or any error register bit is set.
- R8: Channel c is in error when its bus-error and termination-error bits are both set, or when its termination-error bit is set with neither its bus-error bit nor its completion bit set.
- R9: A channel whose completion and termination error are latched in the same cycle, with no bus error, reports a completion event and no error event.
- R10: Pending events form a 32-bit vector: enabled completions in bits 15:0 and error-classified channels in bits 31:16. `evt_valid_o` is high when any bit is set, and `evt_idx_o` gives the highest set position, so the channel is `evt_idx_o` modulo 16.
- R11: After reset, all registers read zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| cmpl_evt_i | input | 16 | Per-channel completion pulses |
| term_err_evt_i | input | 16 | Per-channel termination-error pulses |
| bus_err_evt_i | input | 16 | Per-channel bus-error pulses |
| irq_o | output | 1 | Combined interrupt |
| evt_valid_o | output | 1 | Some event is pending |
| evt_idx_o | output | 5 | Position of the highest pending event |
| freeze_o | output | 16 | Per-channel freeze |
| chan_rst_o | output | 16 | Per-channel one-cycle reset request |
| burst_en_o | output | 2 | Burst enables |

## Verification
The assertions assume that hardware events are only ever sampled as set requests and that the reset request bits change only through register writes. A cycle without a write must therefore leave freeze bits unchanged and reset requests low. The stimulus draws sparse random event pulses and random writes across all addresses and aliases, including the unused alias slot. Directed cases then put a clear and an event on the same bit, and put a termination error together with a completion or with a bus error, so that both classification outcomes are exercised.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } acc_op_e;

  typedef enum logic [1:0] {
    SEL_CMPL  = 2'd0,
    SEL_ERR   = 2'd1,
    SEL_CHCTL = 2'd2,
    SEL_GLB   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_reg.sv
module dma_irq_reg
  import dma_irq_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1,
  parameter logic [W-1:0] AUTO_CLR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  acc_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, base, nxt;

  always_comb begin
    base = q_q & ~AUTO_CLR;
    nxt  = base;
    if (wr_i) begin
      unique case (op_i)
        OP_PLAIN: nxt = wdata_i;
        OP_SET:   nxt = base | wdata_i;
        OP_CLR:   nxt = base & ~wdata_i;
        default:  nxt = base;
      endcase
    end
    // hardware set overrides a same-cycle clear
    nxt = (nxt | hw_set_i) & WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_irq_prio.sv
module dma_irq_prio #(
  parameter int unsigned W = 32,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |vec_i;
endmodule

// File: rtl/dma_irq_csr.sv
module dma_irq_csr
  import dma_irq_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned W     = 2 * NCH,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NCH-1:0]    cmpl_evt_i,
  input  logic [NCH-1:0]    term_err_evt_i,
  input  logic [NCH-1:0]    bus_err_evt_i,
  output logic              irq_o,
  output logic              evt_valid_o,
  output logic [IDX_W-1:0]  evt_idx_o,
  output logic [NCH-1:0]    freeze_o,
  output logic [NCH-1:0]    chan_rst_o,
  output logic [1:0]        burst_en_o
);
  localparam int unsigned BURST_LO = 28;
  localparam logic [REG_W-1:0] GLB_MASK = REG_W'(3) << BURST_LO;
  localparam logic [W-1:0] RST_FIELD = {{NCH{1'b1}}, {NCH{1'b0}}};

  reg_sel_e   sel;
  acc_op_e    op;
  logic       addr_ok;
  logic [3:0] wr;

  assign sel     = reg_sel_e'(addr_i[5:4]);
  assign op      = acc_op_e'(addr_i[3:2]);
  assign addr_ok = (addr_i[ADDR_W-1:6] == '0) && (addr_i[1:0] == 2'b00);

  always_comb begin
    wr = '0;
    if (req_i && we_i && addr_ok && op != OP_NONE) wr[sel] = 1'b1;
  end

  logic [W-1:0]     cmpl_q, err_q, chctl_q;
  logic [REG_W-1:0] glb_q;

  dma_irq_reg #(.W(W)) u_cmpl (
    .clk_i, .rst_ni, .wr_i(wr[SEL_CMPL]), .op_i(op), .wdata_i(wdata_i[W-1:0]),
    .hw_set_i({{NCH{1'b0}}, cmpl_evt_i}), .q_o(cmpl_q)
  );

  dma_irq_reg #(.W(W)) u_err (
    .clk_i, .rst_ni, .wr_i(wr[SEL_ERR]), .op_i(op), .wdata_i(wdata_i[W-1:0]),
    .hw_set_i({bus_err_evt_i, term_err_evt_i}), .q_o(err_q)
  );

  dma_irq_reg #(.W(W), .AUTO_CLR(RST_FIELD)) u_chctl (
    .clk_i, .rst_ni, .wr_i(wr[SEL_CHCTL]), .op_i(op), .wdata_i(wdata_i[W-1:0]),
    .hw_set_i('0), .q_o(chctl_q)
  );

  dma_irq_reg #(.W(REG_W), .WMASK(GLB_MASK)) u_glb (
    .clk_i, .rst_ni, .wr_i(wr[SEL_GLB]), .op_i(op), .wdata_i(wdata_i),
    .hw_set_i('0), .q_o(glb_q)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_ok && op != OP_NONE) begin
      unique case (sel)
        SEL_CMPL:  rdata_o = REG_W'(cmpl_q);
        SEL_ERR:   rdata_o = REG_W'(err_q);
        SEL_CHCTL: rdata_o = REG_W'(chctl_q);
        default:   rdata_o = glb_q;
      endcase
    end
  end

  logic [NCH-1:0] cmpl_en, err_cls;
  assign cmpl_en = cmpl_q[NCH-1:0] & cmpl_q[W-1:NCH];
  // termination error with a completion alongside counts as completed
  assign err_cls = (err_q[W-1:NCH] & err_q[NCH-1:0])
                 | (~err_q[W-1:NCH] & err_q[NCH-1:0] & ~cmpl_q[NCH-1:0]);

  dma_irq_prio #(.W(W)) u_prio (
    .vec_i({err_cls, cmpl_en}), .vld_o(evt_valid_o), .idx_o(evt_idx_o)
  );

  assign irq_o      = (|cmpl_en) | (|err_q);
  assign freeze_o   = chctl_q[NCH-1:0];
  assign chan_rst_o = chctl_q[W-1:NCH];
  assign burst_en_o = glb_q[BURST_LO+1:BURST_LO];
endmodule

// File: rtl/dma_irq_csr_chk.sv
module dma_irq_csr_chk #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned W     = 2 * NCH,
  localparam int unsigned IDX_W = $clog2(W),
  localparam int unsigned CW    = $clog2(NCH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [NCH-1:0]   cmpl_evt_i,
  input logic             irq_o,
  input logic             evt_valid_o,
  input logic [IDX_W-1:0] evt_idx_o,
  input logic [NCH-1:0]   freeze_o,
  input logic [NCH-1:0]   chan_rst_o,
  input logic [W-1:0]     cmpl_q,
  input logic [W-1:0]     err_q
);
  // R4
  cmpl_evt_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cmpl_q[NCH-1:0] & $past(cmpl_evt_i)) == $past(cmpl_evt_i)));

  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> (chan_rst_o == '0));

  // R5
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(freeze_o));

  // R7
  evt_implies_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> irq_o);

  // R8
  err_idx_backed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_idx_o[IDX_W-1]) |-> err_q[evt_idx_o[CW-1:0]]);

  // R10
  cmpl_idx_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_idx_o[IDX_W-1]) |->
      (cmpl_q[evt_idx_o[CW-1:0]] && cmpl_q[NCH + int'(evt_idx_o[CW-1:0])]));
endmodule

bind dma_irq_csr dma_irq_csr_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .cmpl_evt_i(cmpl_evt_i), .irq_o(irq_o), .evt_valid_o(evt_valid_o),
  .evt_idx_o(evt_idx_o), .freeze_o(freeze_o), .chan_rst_o(chan_rst_o),
  .cmpl_q(cmpl_q), .err_q(err_q)
);

// File: tb/dma_irq_csr_tb.sv
module dma_irq_csr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] cmpl_evt_i = '0, term_err_evt_i = '0, bus_err_evt_i = '0;
  logic        irq_o, evt_valid_o;
  logic [4:0]  evt_idx_o;
  logic [15:0] freeze_o, chan_rst_o;
  logic [1:0]  burst_en_o;

  int checks = 0, fails = 0;
  logic [31:0] m_c = '0, m_e = '0, m_ctl = '0, m_glb = '0;

  always #5 clk_i = ~clk_i;

  dma_irq_csr u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cmpl_evt_i, .term_err_evt_i, .bus_err_evt_i,
    .irq_o, .evt_valid_o, .evt_idx_o, .freeze_o, .chan_rst_o, .burst_en_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] apply(input logic [31:0] q, input logic [1:0] op,
                                        input logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return q | d;
      2'd2: return q & ~d;
      default: return q;
    endcase
  endfunction

  function automatic logic [15:0] exp_err_cls();
    return (m_e[31:16] & m_e[15:0]) | (~m_e[31:16] & m_e[15:0] & ~m_c[15:0]);
  endfunction

  function automatic logic [31:0] exp_pend();
    return {exp_err_cls(), m_c[15:0] & m_c[31:16]};
  endfunction

  function automatic logic [4:0] msb(input logic [31:0] v);
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
    return r;
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  // one clock cycle of stimulus, then model update after the edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [15:0] ce, input logic [15:0] te, input logic [15:0] be);
    req_i = we; we_i = we; addr_i = a; wdata_i = d;
    cmpl_evt_i = ce; term_err_evt_i = te; bus_err_evt_i = be;
    @(posedge clk_i);
    m_ctl &= 32'h0000_FFFF;
    if (we && a[7:6] == 2'b00 && a[1:0] == 2'b00 && a[3:2] != 2'd3) begin
      case (a[5:4])
        2'd0: m_c   = apply(m_c, a[3:2], d);
        2'd1: m_e   = apply(m_e, a[3:2], d);
        2'd2: m_ctl = apply(m_ctl, a[3:2], d);
        default: m_glb = apply(m_glb, a[3:2], d) & 32'h3000_0000;
      endcase
    end
    m_c[15:0] |= ce;
    m_e |= {be, te};
    #1;
    req_i = 1'b0; we_i = 1'b0;
    cmpl_evt_i = '0; term_err_evt_i = '0; bus_err_evt_i = '0;
  endtask

  task automatic check_all(input logic [1:0] alias_reg);
    logic [31:0] v;
    logic [31:0] p;
    rd(8'h00, v); check("R1 completion reg", v, m_c);
    rd(8'h10, v); check("R2 error reg", v, m_e);
    rd(8'h20, v); check("R5 channel ctrl reg", v, m_ctl);
    rd(8'h30, v); check("R6 global reg", v, m_glb);
    rd({2'b00, alias_reg, 4'h4}, v);
    check("R3 set alias read", v,
          alias_reg == 0 ? m_c : alias_reg == 1 ? m_e : alias_reg == 2 ? m_ctl : m_glb);
    rd({2'b00, alias_reg, 4'h8}, v);
    check("R3 clear alias read", v,
          alias_reg == 0 ? m_c : alias_reg == 1 ? m_e : alias_reg == 2 ? m_ctl : m_glb);
    p = exp_pend();
    check("R7 irq", 32'(irq_o), 32'((|(m_c[15:0] & m_c[31:16])) | (|m_e)));
    check("R10 evt_valid", 32'(evt_valid_o), 32'(|p));
    if (|p) check("R10 evt_idx", 32'(evt_idx_o), 32'(msb(p)));
    check("R5 freeze_o", 32'(freeze_o), 32'(m_ctl[15:0]));
    check("R5 chan_rst_o", 32'(chan_rst_o), 32'(m_ctl[31:16]));
    check("R6 burst_en_o", 32'(burst_en_o), 32'({m_glb[29], m_glb[28]}));
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    #2;
    // R11 reset state
    rd(8'h00, v); check("R11 completion after reset", v, 0);
    rd(8'h10, v); check("R11 error after reset", v, 0);
    check("R11 outputs after reset",
          {irq_o, evt_valid_o, evt_idx_o, freeze_o, chan_rst_o, burst_en_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all(2'd0);

    // R4 hw set beats a same-cycle clear
    cyc(1'b0, 8'h00, 0, 16'h0008, 0, 0);
    cyc(1'b1, 8'h08, 32'h0000_0008, 16'h0008, 0, 0);
    rd(8'h00, v); check("R4 set wins over clear", v & 32'h8, 32'h8);
    cyc(1'b1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(1'b1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    check_all(2'd0);

    // R9 completion and termination error together on channel 5
    cyc(1'b1, 8'h04, 32'h0020_0000, 0, 0, 0);
    cyc(1'b0, 8'h00, 0, 16'h0020, 16'h0020, 0);
    check("R9 valid", 32'(evt_valid_o), 1);
    check("R9 reported as completion", 32'(evt_idx_o), 5);
    check_all(2'd1);

    // R8 bus plus termination error on channel 7 outranks completion
    cyc(1'b0, 8'h00, 0, 0, 16'h0080, 16'h0080);
    check("R8 bus+term error idx", 32'(evt_idx_o), 23);
    cyc(1'b1, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(1'b1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    // R8 termination alone is an error; bus alone is not
    cyc(1'b0, 8'h00, 0, 0, 16'h0002, 16'h0400);
    check("R8 term-only error idx", 32'(evt_idx_o), 17);
    check("R7 irq with errors", 32'(irq_o), 1);
    cyc(1'b1, 8'h18, 32'h0000_0002, 0, 0, 0);
    check("R8 bus-only not an event", 32'(evt_valid_o), 0);
    check("R7 bus-only still raises irq", 32'(irq_o), 1);
    check_all(2'd1);

    // R5 reset request pulse
    cyc(1'b1, 8'h24, 32'h0010_0003, 0, 0, 0);
    check("R5 reset request high", 32'(chan_rst_o), 32'h0010);
    check("R5 freeze set", 32'(freeze_o), 32'h0003);
    cyc(1'b0, 8'h00, 0, 0, 0, 0);
    check("R5 reset request self clears", 32'(chan_rst_o), 0);
    check_all(2'd2);

    // R6 global reg mask, R3 unused slot
    cyc(1'b1, 8'h30, 32'hFFFF_FFFF, 0, 0, 0);
    rd(8'h30, v); check("R6 only burst bits kept", v, 32'h3000_0000);
    cyc(1'b1, 8'h3C, 32'h0, 0, 0, 0);
    rd(8'h3C, v); check("R3 unused slot reads zero", v, 0);
    check("R3 unused slot write ignored", 32'(burst_en_o), 3);
    check_all(2'd3);

    // R10 highest completion channel wins among several
    cyc(1'b1, 8'h00, 32'hFFFF_0000, 0, 0, 0);
    cyc(1'b1, 8'h10, 32'h0, 0, 0, 0);
    cyc(1'b0, 8'h00, 0, 16'h0412, 0, 0);
    check("R10 highest completion", 32'(evt_idx_o), 10);
    check_all(2'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = {($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00, 2'($urandom),
           2'($urandom), ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00};
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc(1'($urandom_range(0, 1)), a, d,
          16'($urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom & $urandom));
      check_all(2'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule